// File: doc/BRIEF.md
# PLL Lock and Oscillator Warm-up Timer

This block sequences the switch-over of a system clock from the raw high-speed oscillator to a PLL output running at four times that frequency. The analog parts live elsewhere. This block only produces the timing and the select signal. When reset is released, the block samples an enable strap once. That sampled value decides for the whole reset session whether the PLL clock may ever be selected.

One counter serves two purposes: it times the oscillator warm-up and it times the PLL lock. Software launches a count by writing a start bit through a small register port. In the same write it can pick the long interval (2^LONG_LOG2 cycles, 65536 by default) or the short one (2^SHORT_LOG2 cycles, 4096 by default). An out-of-lock status bit reads 1 until a count completes. A standby-exit pulse returns the block to the out-of-lock state, so software must run a fresh count before the multiplied clock is selected again.

Top module: `pll_lock_ctl`

## Requirements
- R1: While rst_n is low, status_unlocked is 1, clk_sel_pll is 0, pll_enabled is 0 and lock_sel_short is 0 (long interval).
- R2: pll_enabled takes the value of strap_pll_en at the first rising clock edge after rst_n goes high. Later changes of the strap leave pll_enabled unchanged until the next reset.
- R3: With pll_enabled at 0, clk_sel_pll stays 0 even after a count completes.
- R4: A reg_wr cycle with reg_wdata[0]=1 (start) and reg_wdata[1]=0 holds status_unlocked at 1 for exactly 2^LONG_LOG2 rising edges after the write edge. The bit clears on the next edge.
- R5: A start write with reg_wdata[1]=1 uses an interval of 2^SHORT_LOG2 edges instead. The interval is set by the write that launched the count.
- R6: clk_sel_pll is 1 exactly when pll_enabled is 1 and status_unlocked is 0. It rises only on the edge that ends a count.
- R7: A start write issued while a count is running restarts the count from zero and sets status_unlocked to 1.
- R8: A standby_exit pulse sets status_unlocked to 1 and clk_sel_pll to 0 on the next edge and starts no count. It overrides a start write in the same cycle.
- R9: A write with reg_wdata[0]=0 starts no count and leaves the lock state and clk_sel_pll unchanged.
- R10: lock_sel_short returns reg_wdata[1] of the most recent write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_pll_en | input | 1 | PLL enable strap, sampled once after reset release |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 2 | bit0 start count, bit1 short interval select |
| standby_exit | input | 1 | Pulse on leaving standby; drops lock |
| status_unlocked | output | 1 | 1 while the PLL counts as out of lock |
| lock_sel_short | output | 1 | Readback of the interval select bit |
| pll_enabled | output | 1 | Sampled strap value |
| clk_sel_pll | output | 1 | 1 selects the multiplied PLL clock |

## Verification
The main function is driven with long counts, short counts, restarts in the middle of a count and writes that carry no start bit. These cases separate an off-by-one terminal count from a correct one, show whether the interval is latched when the count launches, and show whether an idle write disturbs lock. A standby pulse issued alone and a standby pulse that coincides with a start write separate the abort priority from the restart behaviour. Runs with the strap low and with the strap changing after reset show whether clock selection is gated by the value sampled once at reset release.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

    typedef struct packed {
        logic running;
        logic use_short;
    } cnt_ctl_t;

    typedef struct packed {
        logic sampled;
        logic enabled;
    } strap_t;

    typedef struct packed {
        logic locked;
        logic sel_short;
    } lock_t;

endpackage

// File: rtl/pll_strap_latch.sv
module pll_strap_latch
    import pll_lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strap_in,
    output logic enabled
);

    strap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.sampled) begin
            st_d.sampled = 1'b1;
            st_d.enabled = strap_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enabled = st_q.enabled;

    // R2: once sampled, the enable never moves again
    a_r2_strap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sampled |=> $stable(enabled));

endmodule

// File: rtl/pll_lock_counter.sv
module pll_lock_counter
    import pll_lock_pkg::*;
#(
    parameter int LONG_LOG2  = 16,
    parameter int SHORT_LOG2 = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic abort,
    input  logic short_req,
    output logic running,
    output logic expire
);

    localparam int CNT_W = LONG_LOG2;
    localparam logic [CNT_W-1:0] LONG_TERM  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] SHORT_TERM = CNT_W'((64'd1 << SHORT_LOG2) - 64'd1);

    cnt_ctl_t         ctl_d, ctl_q;
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] term;

    assign term   = ctl_q.use_short ? SHORT_TERM : LONG_TERM;
    assign expire = ctl_q.running && (cnt_q == term);

    always_comb begin
        ctl_d = ctl_q;
        cnt_d = cnt_q;
        if (abort) begin
            ctl_d.running = 1'b0;
            cnt_d         = '0;
        end else if (restart) begin
            ctl_d.running   = 1'b1;
            ctl_d.use_short = short_req;
            cnt_d           = '0;
        end else if (ctl_q.running) begin
            if (cnt_q == term) begin
                ctl_d.running = 1'b0;
                cnt_d         = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            cnt_q <= '0;
        end else begin
            ctl_q <= ctl_d;
            cnt_q <= cnt_d;
        end
    end

    assign running = ctl_q.running;

    // R7: a restart always begins again at zero
    a_r7_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !abort) |=> (running && cnt_q == '0));

    // R4: the count never runs past its terminal value
    a_r4_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt_q <= term));

    // R8: abort leaves the counter idle
    a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !running);

endmodule

// File: rtl/pll_lock_ctl.sv
module pll_lock_ctl
    import pll_lock_pkg::*;
#(
    parameter int LONG_LOG2  = 16,
    parameter int SHORT_LOG2 = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_pll_en,
    input  logic       reg_wr,
    input  logic [1:0] reg_wdata,
    input  logic       standby_exit,
    output logic       status_unlocked,
    output logic       lock_sel_short,
    output logic       pll_enabled,
    output logic       clk_sel_pll
);

    lock_t lk_d, lk_q;
    logic  start_req;
    logic  cnt_running;
    logic  cnt_expire;

    assign start_req = reg_wr && reg_wdata[0];

    pll_strap_latch i_strap (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_in (strap_pll_en),
        .enabled  (pll_enabled)
    );

    pll_lock_counter #(
        .LONG_LOG2  (LONG_LOG2),
        .SHORT_LOG2 (SHORT_LOG2)
    ) i_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (start_req),
        .abort     (standby_exit),
        .short_req (reg_wdata[1]),
        .running   (cnt_running),
        .expire    (cnt_expire)
    );

    always_comb begin
        lk_d = lk_q;
        if (reg_wr) lk_d.sel_short = reg_wdata[1];
        if (standby_exit)    lk_d.locked = 1'b0;
        else if (start_req)  lk_d.locked = 1'b0;
        else if (cnt_expire) lk_d.locked = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

    assign status_unlocked = !lk_q.locked;
    assign lock_sel_short  = lk_q.sel_short;
    assign clk_sel_pll     = pll_enabled && lk_q.locked;

    // R6: the PLL clock is picked only on the edge that ends a count
    a_r6_sel_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_sel_pll) |-> $past(cnt_expire));

    // R8: leaving standby drops lock and the PLL clock
    a_r8_standby_drop: assert property (@(posedge clk) disable iff (!rst_n)
        standby_exit |=> (status_unlocked && !clk_sel_pll));

    // R4: a start write puts the block out of lock
    a_r4_start_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> status_unlocked);

    // R4: lock is never declared while the counter is still counting
    a_r4_lock_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_running |-> status_unlocked);

endmodule

// File: tb/test_pll_lock_ctl.sv
module test_pll_lock_ctl;

    localparam int LG = 10;
    localparam int SG = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap = 1'b1;
    logic       wr = 1'b0;
    logic [1:0] wd = 2'b00;
    logic       stb = 1'b0;
    logic       busy, lsel, pen, csel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pll_lock_ctl #(.LONG_LOG2(LG), .SHORT_LOG2(SG)) i_pll_lock_ctl (
        .clk(clk), .rst_n(rst_n), .strap_pll_en(strap), .reg_wr(wr),
        .reg_wdata(wd), .standby_exit(stb), .status_unlocked(busy),
        .lock_sel_short(lsel), .pll_enabled(pen), .clk_sel_pll(csel)
    );

    typedef struct packed {
        logic [1:0]  op;    // 0 write, 1 wait, 2 standby pulse
        logic [1:0]  wdat;
        logic [15:0] cyc;
        logic        e_busy;
        logic        e_sel;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [0:NV-1] = '{
        '{2'd0, 2'b01, 16'd1023, 1'b1, 1'b0, 4'd4},  // R4 last busy edge
        '{2'd1, 2'b00, 16'd1,    1'b0, 1'b1, 4'd6},  // R6 lock, PLL clock
        '{2'd0, 2'b11, 16'd63,   1'b1, 1'b0, 4'd5},  // R5 short, last busy
        '{2'd1, 2'b00, 16'd1,    1'b0, 1'b1, 4'd5},  // R5 short done
        '{2'd0, 2'b10, 16'd5,    1'b0, 1'b1, 4'd9},  // R9 no start
        '{2'd0, 2'b01, 16'd500,  1'b1, 1'b0, 4'd4},  // R4 mid count
        '{2'd0, 2'b01, 16'd1023, 1'b1, 1'b0, 4'd7},  // R7 restart
        '{2'd1, 2'b00, 16'd1,    1'b0, 1'b1, 4'd7},  // R7 done after full run
        '{2'd2, 2'b00, 16'd0,    1'b1, 1'b0, 4'd8},  // R8 standby drop
        '{2'd1, 2'b00, 16'd2000, 1'b1, 1'b0, 4'd8},  // R8 no count started
        '{2'd0, 2'b11, 16'd64,   1'b0, 1'b1, 4'd5},  // R5 short relock
        '{2'd0, 2'b00, 16'd3,    1'b0, 1'b1, 4'd9}   // R9 idle write
    };

    task automatic chk(input string rq, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", rq, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] d);
        @(negedge clk); wr = 1'b1; wd = d;
        @(posedge clk);
        @(negedge clk); wr = 1'b0; wd = 2'b00;
    endtask

    task automatic wait_edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1", "status", busy, 1'b1);
        chk("R1", "clk_sel", csel, 1'b0);
        chk("R1", "pll_en", pen, 1'b0);
        chk("R1", "lock_sel", lsel, 1'b0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R2", "pll_en sampled high", pen, 1'b1);
        chk("R1", "status after reset", busy, 1'b1);

        for (int v = 0; v < NV; v++) begin
            if (VECS[v].op == 2'd0) begin
                @(negedge clk); wr = 1'b1; wd = VECS[v].wdat;
                @(posedge clk);
                for (int i = 0; i < int'(VECS[v].cyc); i++) begin
                    @(negedge clk); wr = 1'b0; wd = 2'b00;
                    @(posedge clk);
                end
                @(negedge clk); wr = 1'b0; wd = 2'b00;
            end else if (VECS[v].op == 2'd2) begin
                @(negedge clk); stb = 1'b1;
                @(posedge clk);
                @(negedge clk); stb = 1'b0;
            end else begin
                for (int i = 0; i < int'(VECS[v].cyc); i++) @(posedge clk);
                @(negedge clk);
            end
            chk($sformatf("R%0d", VECS[v].req), "status", busy, VECS[v].e_busy);
            chk($sformatf("R%0d", VECS[v].req), "clk_sel", csel, VECS[v].e_sel);
            if (v == 10) chk("R10", "lock_sel after short", lsel, 1'b1);
            if (v == 11) chk("R10", "lock_sel after idle write", lsel, 1'b0);
        end

        // R8: standby wins over a coincident start
        @(negedge clk); stb = 1'b1; wr = 1'b1; wd = 2'b11;
        @(posedge clk);
        @(negedge clk); stb = 1'b0; wr = 1'b0; wd = 2'b00;
        wait_edges(100);
        chk("R8", "status after standby+start", busy, 1'b1);
        chk("R8", "clk_sel after standby+start", csel, 1'b0);

        // R10 readback of a select-only write
        do_write(2'b10);
        chk("R10", "lock_sel readback", lsel, 1'b1);

        // R2: strap change after sampling is ignored
        strap = 1'b0;
        wait_edges(5);
        chk("R2", "pll_en holds", pen, 1'b1);

        // R3: strap low at reset release keeps the oscillator clock
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "status in reset", busy, 1'b1);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk); strap = 1'b1;
        chk("R2", "pll_en sampled low", pen, 1'b0);
        do_write(2'b11);
        wait_edges(70);
        chk("R3", "status locked", busy, 1'b0);
        chk("R3", "clk_sel stays osc", csel, 1'b0);
        chk("R3", "pll_en off", pen, 1'b0);

        finish_run();
    end

endmodule